// File: doc/BRIEF.md
# SMBus Master SCL Clock Generator with Slave Inhibit

This block times the SCL line of a two-wire SMBus-style master. It does not use a private divider. It counts overflow strobes from one of four shared timers, and a two-bit field in its configuration word picks the timer. Each SCL low phase lasts two selected strobes. The high phase lasts one strobe, and that count starts only once SCL is actually sampled high, so another device can stretch the clock. With no stretching, one bit takes three strobe periods. The timers are never stopped or reloaded, because the block only watches their overflow pulses.

The same configuration word holds the following controls:
- a global enable,
- a master-clocking enable,
- a bus-free detection enable,
- a slave-inhibit bit.

The block answers each received address with an ACK or NACK decision and raises a one-cycle slave interrupt. While inhibited it keeps watching SCL and SDA, but it NACKs addresses and stays quiet. A change to the inhibit bit only takes effect at the next detected START, so a transfer already under way completes with the old setting. A simple tick counter reports when both lines have been high long enough for the bus to count as free.

Top module: `smb_sclgen_top`

## Requirements
- R1: The clock select field picks the strobe source: code 0 uses `tick_i[0]`, code 1 uses `tick_i[1]`, code 2 uses `tick_i[2]` and code 3 uses `tick_i[3]`. With strobes every P cycles and no stretching, the SCL period is 3*P clock cycles.
- R2: With master clocking on, `scl_drive_low` stays asserted for `LOW_TICKS` (default 2) selected strobes. It is then released, and after SCL is sampled high, `HIGH_TICKS` (default 1) further strobes pass before the next low phase. A low phase lasts at least two cycles unless master clocking is switched off.
- R3: If SCL is still sampled low after release, the block keeps SCL released and does not start the high-phase count until SCL is seen high. A stretched bit is longer than 3*P cycles.
- R4: Strobes are ignored unless master clocking or bus-free detection is active. With both off, `scl_drive_low` and `bus_free` stay 0.
- R5: With the enable bit clear, the block drives no SCL, NACKs every address (`addr_ack` = 0) and raises no interrupt.
- R6: With enable set and inhibit not active, an `addr_rcv` pulse sets `addr_ack` to 1 one cycle later. `addr_ack` holds until the next `addr_rcv`. `slv_irq` pulses for exactly that one cycle.
- R7: While inhibit is active, received addresses are NACKed and `slv_irq` stays 0.
- R8: The active inhibit state takes the configured inhibit bit only in the cycle after a `start_det` pulse. Before that START, addresses are handled with the previous setting.
- R9: With bus-free detection active, `bus_free` rises on the `FREE_TICKS`-th (default 8) selected strobe during which SCL and SDA have both stayed high. The flag clears in the cycle after a `start_det`, after either line is low, or after detection is turned off.
- R10: A `cfg_we` pulse loads `cfg_wdata` in one cycle. The fields are bit0 enable, bit1 inhibit, bits3:2 clock select, bit4 master clocking and bit5 bus-free detection. After reset all fields are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 4 | Overflow strobes from the four shared timers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| start_det | input | 1 | START condition detected (one-cycle strobe) |
| addr_rcv | input | 1 | Slave address received (one-cycle strobe) |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| addr_ack | output | 1 | ACK (1) or NACK (0) decision for the last address |
| slv_irq | output | 1 | One-cycle slave interrupt request |
| bus_free | output | 1 | Both lines have been idle for the configured strobe count |

## Verification
The assertions check the following on every cycle:
- SCL is only pulled while master clocking was on.
- A started low phase is not cut short.
- Interrupts only follow an address strobe and only while inhibit is not active.
- The active inhibit state moves only after a START.
- The free flag is cleared by a START and never stands while a line was low.

The exact SCL period for each select code, the lengthening of a stretched bit, the two-phase handover of the inhibit bit around a START, and the strobe count to the free flag need timed stimulus. Only the bench scenarios and its per-cycle reference model show those.

// File: rtl/smb_sclgen_pkg.sv
// Package: shared types for the SMBus SCL generator.
// Assumes the configuration word is written as one packed vector, enable in bit 0.
package smb_sclgen_pkg;

    // Strobe source codes; the code value is the index into tick_i.
    typedef enum logic [1:0] {
        SRC_TMR0  = 2'd0,
        SRC_TMR1  = 2'd1,
        SRC_TMR2H = 2'd2,
        SRC_TMR2L = 2'd3
    } src_sel_e;

    // Configuration word; packed MSB first so enable lands in bit 0.
    typedef struct packed {
        logic     free_en;   // bit 5
        logic     mst_en;    // bit 4
        src_sel_e src;       // bits 3:2
        logic     inhibit;   // bit 1
        logic     enable;    // bit 0
    } cfg_t;

    // Phases of the master SCL sequence.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_ph_e;

endpackage

// File: rtl/smb_tick_sel.sv
// Module: picks one of N_SRC overflow strobes by code and passes it on only
// when a consumer is active. Assumes strobes are single-cycle pulses.
module smb_tick_sel #(
    parameter  int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    input  logic             consume,
    output logic             tick
);

    logic [N_SRC-1:0] hit;

    // One decoder slice for each strobe source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ticks[g] && (sel == SEL_W'(g));
    end

    // Forward the chosen strobe only to an active consumer.
    assign tick = consume && (|hit);

endmodule

// File: rtl/smb_scl_phase.sv
// Module: master SCL phase sequencer. It pulls SCL low for LOW_TICKS strobes,
// releases it, waits until SCL reads high (stretch support), then counts
// HIGH_TICKS strobes. Assumes scl_in is already synchronised.
module smb_scl_phase
    import smb_sclgen_pkg::*;
#(
    parameter  int LOW_TICKS  = 2,
    parameter  int HIGH_TICKS = 1,
    localparam int MAX_TICKS  = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS,
    localparam int CNT_W      = $clog2(MAX_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic scl_in,
    output logic drive_low
);

    scl_ph_e            ph_q;
    logic [CNT_W-1:0]   cnt_q;

    // Advance the phase sequence and its strobe counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    ph_q  <= PH_LOW;
                    cnt_q <= '0;
                end
                PH_LOW: if (tick) begin
                    if (cnt_q == CNT_W'(LOW_TICKS - 1)) begin
                        ph_q  <= PH_WAIT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WAIT: if (scl_in) begin
                    ph_q  <= PH_HIGH;
                    cnt_q <= '0;
                end
                PH_HIGH: if (tick) begin
                    if (cnt_q == CNT_W'(HIGH_TICKS - 1)) begin
                        ph_q  <= PH_LOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // SCL is pulled only during the low phase.
    assign drive_low = (ph_q == PH_LOW);

endmodule

// File: rtl/smb_bus_idle.sv
// Module: bus-free detector. It counts selected strobes while SCL and SDA are
// both high and flags free at FREE_TICKS. A START, a low line or disable
// clears it. Assumes inputs are synchronised.
module smb_bus_idle #(
    parameter  int FREE_TICKS = 8,
    localparam int CNT_W      = $clog2(FREE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_det,
    output logic free
);

    logic [CNT_W-1:0] cnt_q;
    logic             free_q;

    // Count idle strobes and hold the free flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !on || start_det || !(scl_in && sda_in)) begin
            cnt_q  <= '0;
            free_q <= 1'b0;
        end else if (tick && !free_q) begin
            if (cnt_q == CNT_W'(FREE_TICKS - 1)) begin
                free_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign free = free_q;

endmodule

// File: rtl/smb_slave_gate.sv
// Module: slave-event gate. It latches the inhibit bit at each START and
// decides ACK/NACK and the interrupt for each received address. Assumes
// start_det and addr_rcv are single-cycle strobes.
module smb_slave_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic inhibit_cfg,
    input  logic start_det,
    input  logic addr_rcv,
    output logic inh_act,
    output logic addr_ack,
    output logic slv_irq
);

    logic inh_q, ack_q, irq_q;

    // Take the configured inhibit bit into effect only at a START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q <= 1'b0;
        end else if (start_det) begin
            inh_q <= inhibit_cfg;
        end
    end

    // Decide acknowledge and interrupt on each received address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= addr_rcv && enable && !inh_q;
            if (addr_rcv) begin
                ack_q <= enable && !inh_q;
            end
        end
    end

    assign inh_act  = inh_q;
    assign addr_ack = ack_q;
    assign slv_irq  = irq_q;

endmodule

// File: rtl/smb_sclgen_top.sv
// Module: SMBus master SCL generator top. It holds the configuration word,
// gates the shared timer strobes and joins the phase sequencer, bus-free
// detector and slave gate. Assumes all line and strobe inputs are synchronous.
module smb_sclgen_top
    import smb_sclgen_pkg::*;
#(
    parameter  int LOW_TICKS  = 2,
    parameter  int HIGH_TICKS = 1,
    parameter  int FREE_TICKS = 8,
    localparam int N_SRC      = 4,
    localparam int CFG_W      = $bits(cfg_t)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick_i,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             start_det,
    input  logic             addr_rcv,
    output logic             scl_drive_low,
    output logic             addr_ack,
    output logic             slv_irq,
    output logic             bus_free
);

    cfg_t cfg_q;
    logic master_on, free_on, sel_tick, inh_active;

    // Load the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_t'(cfg_wdata);
        end
    end

    assign master_on = cfg_q.enable && cfg_q.mst_en;
    assign free_on   = cfg_q.enable && cfg_q.free_en;

    smb_tick_sel #(.N_SRC(N_SRC)) u_sel (
        .ticks   (tick_i),
        .sel     (cfg_q.src),
        .consume (master_on || free_on),
        .tick    (sel_tick)
    );

    smb_scl_phase #(.LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (master_on),
        .tick      (sel_tick),
        .scl_in    (scl_in),
        .drive_low (scl_drive_low)
    );

    smb_bus_idle #(.FREE_TICKS(FREE_TICKS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .on        (free_on),
        .tick      (sel_tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .free      (bus_free)
    );

    smb_slave_gate u_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_q.enable),
        .inhibit_cfg (cfg_q.inhibit),
        .start_det   (start_det),
        .addr_rcv    (addr_rcv),
        .inh_act     (inh_active),
        .addr_ack    (addr_ack),
        .slv_irq     (slv_irq)
    );

endmodule

// File: rtl/smb_sclgen_chk.sv
// Module: assertion checker for smb_sclgen_top, attached by bind below.
module smb_sclgen_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_drive_low,
    input logic m_on,
    input logic addr_rcv,
    input logic slv_irq,
    input logic inh_act,
    input logic start_det,
    input logic bus_free,
    input logic scl_in,
    input logic sda_in
);

    AST_DRIVE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> $past(m_on)); // R5
    AST_LOW_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |=> (scl_drive_low || !$past(m_on))); // R2
    AST_IRQ_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        slv_irq |-> $past(addr_rcv)); // R6
    AST_IRQ_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        slv_irq |-> !$past(inh_act)); // R7
    AST_INHIBIT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start_det |=> $stable(inh_act)); // R8
    AST_FREE_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_free); // R9
    AST_FREE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(scl_in && sda_in)); // R9

endmodule

bind smb_sclgen_top smb_sclgen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_drive_low (scl_drive_low),
    .m_on          (master_on),
    .addr_rcv      (addr_rcv),
    .slv_irq       (slv_irq),
    .inh_act       (inh_active),
    .start_det     (start_det),
    .bus_free      (bus_free),
    .scl_in        (scl_in),
    .sda_in        (sda_in)
);

// File: tb/smb_sclgen_top_tb_top.sv
// Bench: per-cycle behavioural reference model plus timed scenarios.
module smb_sclgen_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FREE_N     = 8;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] tick_i;
    logic       cfg_we;
    logic [5:0] cfg_wdata;
    logic       scl_in, sda_in, start_det, addr_rcv, stretch;
    logic       scl_drive_low, addr_ack, slv_irq, bus_free;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain SCL line: pulled by the block or by a stretching device.
    assign scl_in = !(scl_drive_low || stretch);

    smb_sclgen_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .scl_in(scl_in), .sda_in(sda_in),
        .start_det(start_det), .addr_rcv(addr_rcv),
        .scl_drive_low(scl_drive_low), .addr_ack(addr_ack),
        .slv_irq(slv_irq), .bus_free(bus_free)
    );

    // Timer strobes: source k pulses every 4+k cycles.
    int tcnt [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            tick_i[k] <= (tcnt[k] == 0);
            tcnt[k]   <= (tcnt[k] == 3 + k) ? 0 : tcnt[k] + 1;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model state.
    bit m_en, m_inh, m_mst, m_fe, m_drive, m_free, m_inh_act, m_ack, m_irq;
    int m_sel, m_ph, m_cnt, m_fcnt;

    always @(posedge clk) begin
        bit scl, mon, fon, tk;
        if (!rst_n) begin
            m_en = 0; m_inh = 0; m_mst = 0; m_fe = 0; m_sel = 0;
            m_drive = 0; m_free = 0; m_inh_act = 0; m_ack = 0; m_irq = 0;
            m_ph = 0; m_cnt = 0; m_fcnt = 0;
        end else begin
            scl = !(m_drive || stretch);
            mon = m_en && m_mst;
            fon = m_en && m_fe;
            tk  = (mon || fon) && tick_i[m_sel];
            if (!mon) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cnt = 0;
            end else if (m_ph == 1) begin
                if (tk) m_cnt++;
                if (m_cnt == 2) begin m_ph = 2; m_cnt = 0; end
            end else if (m_ph == 2) begin
                if (scl) m_ph = 3;
            end else if (tk) begin
                m_ph = 1; m_cnt = 0;
            end
            m_drive = (m_ph == 1);
            if (!fon || start_det || !(scl && sda_in)) begin
                m_fcnt = 0; m_free = 0;
            end else if (tk && !m_free) begin
                m_fcnt++;
                if (m_fcnt == FREE_N) m_free = 1;
            end
            m_irq = addr_rcv && m_en && !m_inh_act;
            if (addr_rcv) m_ack = m_en && !m_inh_act;
            if (start_det) m_inh_act = m_inh;
            if (cfg_we) begin
                m_en = cfg_wdata[0]; m_inh = cfg_wdata[1];
                m_sel = int'(cfg_wdata[3:2]); m_mst = cfg_wdata[4]; m_fe = cfg_wdata[5];
            end
        end
    end

    // Compare the design against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            check(scl_drive_low == m_drive, "R2 model scl_drive_low", scl_drive_low, m_drive);
            check(addr_ack == m_ack, "R6 model addr_ack", addr_ack, m_ack);
            check(slv_irq == m_irq, "R7 model slv_irq", slv_irq, m_irq);
            check(bus_free == m_free, "R9 model bus_free", bus_free, m_free);
        end
    end

    function automatic logic [5:0] cfgv(bit en, bit inh, int sel, bit mst, bit fe);
        return {fe, mst, 2'(sel), inh, en};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_rise(output int c);
        logic p;
        bit   hit;
        p = scl_drive_low; hit = 0;
        while (!hit) begin
            @(negedge clk);
            if (scl_drive_low && !p) hit = 1;
            p = scl_drive_low;
        end
        c = cyc;
    endtask

    task automatic addr_pulse(output logic ack, output logic irq);
        addr_rcv = 1;
        @(negedge clk);
        addr_rcv = 0;
        ack = addr_ack; irq = slv_irq;
    endtask

    task automatic start_pulse;
        start_det = 1;
        @(negedge clk);
        start_det = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int r0, r1, r2, n, bad;
        logic ack, irq;
        rst_n = 0; cfg_we = 0; cfg_wdata = 0; sda_in = 1;
        start_det = 0; addr_rcv = 0; stretch = 0;
        step(3);
        rst_n = 1;
        @(negedge clk);
        check({scl_drive_low, addr_ack, slv_irq, bus_free} == 4'b0, "R10 reset outputs",
              int'({scl_drive_low, addr_ack, slv_irq, bus_free}), 0);

        // R1 R2: period and low time for each select code.
        for (int s = 0; s < 4; s++) begin
            wr_cfg(cfgv(1, 0, s, 0, 0));
            step(3);
            wr_cfg(cfgv(1, 0, s, 1, 0));
            wait_rise(r0); wait_rise(r1); wait_rise(r2);
            check(r2 - r1 == 3 * (4 + s), "R1 SCL period for select code", r2 - r1, 3 * (4 + s));
            n = 1;
            @(negedge clk);
            while (scl_drive_low) begin n++; @(negedge clk); end
            check(n == 2 * (4 + s), "R2 SCL low phase cycles", n, 2 * (4 + s));
        end

        // R3: clock stretching lengthens the bit.
        wr_cfg(cfgv(1, 0, 0, 0, 0));
        step(3);
        wr_cfg(cfgv(1, 0, 0, 1, 0));
        wait_rise(r0); wait_rise(r0);
        while (scl_drive_low) @(negedge clk);
        stretch = 1;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (scl_drive_low) bad++;
        end
        stretch = 0;
        check(bad == 0, "R3 no pull during stretch", bad, 0);
        wait_rise(r1);
        check(r1 - r0 > 12, "R3 stretched period longer than 3P", r1 - r0, 13);

        // R4: strobes ignored with both consumers off.
        wr_cfg(cfgv(1, 0, 0, 0, 0));
        step(2);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_drive_low || bus_free) bad++;
        end
        check(bad == 0, "R4 idle with consumers off", bad, 0);

        // R5: enable clear blocks master and slave events.
        wr_cfg(cfgv(0, 0, 0, 1, 1));
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_drive_low || bus_free) bad++;
        end
        check(bad == 0, "R5 no drive while disabled", bad, 0);
        addr_pulse(ack, irq);
        check(ack == 0 && irq == 0, "R5 NACK and no irq while disabled", int'({ack, irq}), 0);

        // R6: normal acknowledge and one-cycle interrupt.
        wr_cfg(cfgv(1, 0, 0, 0, 0));
        addr_pulse(ack, irq);
        check(ack == 1 && irq == 1, "R6 ACK and irq", int'({ack, irq}), 3);
        @(negedge clk);
        check(slv_irq == 0 && addr_ack == 1, "R6 irq one cycle, ack held",
              int'({addr_ack, slv_irq}), 2);

        // R8 R7: inhibit takes effect only after START.
        wr_cfg(cfgv(1, 1, 0, 0, 0));
        addr_pulse(ack, irq);
        check(ack == 1 && irq == 1, "R8 old setting before START", int'({ack, irq}), 3);
        start_pulse();
        addr_pulse(ack, irq);
        check(ack == 0 && irq == 0, "R7 inhibited NACK no irq", int'({ack, irq}), 0);
        wr_cfg(cfgv(1, 0, 0, 0, 0));
        addr_pulse(ack, irq);
        check(ack == 0 && irq == 0, "R8 clear waits for START", int'({ack, irq}), 0);
        start_pulse();
        addr_pulse(ack, irq);
        check(ack == 1 && irq == 1, "R8 cleared after START", int'({ack, irq}), 3);

        // R9: bus-free detection.
        wr_cfg(cfgv(1, 0, 0, 0, 1));
        sda_in = 1;
        start_pulse();
        step(20);
        check(bus_free == 0, "R9 not free before count", bus_free, 0);
        step(25);
        check(bus_free == 1, "R9 free after count", bus_free, 1);
        start_pulse();
        check(bus_free == 0, "R9 START clears flag", bus_free, 0);
        step(40);
        check(bus_free == 1, "R9 free again", bus_free, 1);
        sda_in = 0;
        @(negedge clk);
        check(bus_free == 0, "R9 low SDA clears flag", bus_free, 0);
        sda_in = 1;
        step(5);
        finish_run();
    end

endmodule